// File: doc/BRIEF.md
# Relative Branch and Skip Resolver

This block chooses the program counter that follows the current instruction in a small byte-addressed core with 2-byte instruction words. Each request carries the current PC, a 5-bit operation class, a signed word displacement, four status flags, the working register and a data operand with a bit index. The block resolves one of three outcomes: a PC-relative jump, a skip past the next instruction word, or plain sequential flow. It also supplies the return address to push when the operation is a relative call.

The decision covers nine flag-conditioned or unconditional relative jumps and the relative call. It also covers skips on a tested operand bit, on an unsigned comparison of the operand with the working register, on the wrapped result of incrementing or decrementing the operand, and on a zero operand. The block computes the incremented or decremented value only to make the skip decision; writing that value back and every flag update belong to the datapath. One register stage sits between the request and the result. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `bsd_branch_unit`

## Requirements
- R1: While reset is asserted, and after its release until the first request, res_valid, taken, skip_next and push_en are 0 and next_pc and push_addr are all zeros.
- R2: A request presented with op_valid high at a rising edge produces res_valid high after that edge. A cycle with op_valid low produces res_valid, taken, skip_next and push_en low after the next edge.
- R3: A taken relative jump sets next_pc to pc + 2 + 2*d modulo 2^PC_W, where d is br_ofs read as a two's-complement number.
- R4: The status flags occupy flags bit 0 = carry, bit 1 = zero, bit 2 = overflow and bit 3 = negative. The class codes are: 1 jumps always; 2 jumps if carry is set and 3 if it is clear; 4 jumps if negative is set and 5 if it is clear; 6 jumps if overflow is set and 7 if it is clear; 8 jumps if zero is set and 9 if it is clear.
- R5: Class 10 is a relative call. It always jumps as in R3, sets push_en, and drives push_addr to pc + 2.
- R6: Class 11 skips when bit fop[bit_sel] is 0. Class 12 skips when that bit is 1.
- R7: Classes 13, 14 and 15 skip when fop equals wreg, when fop is greater than wreg, and when fop is less than wreg, respectively. Both comparisons are unsigned.
- R8: Classes 16 and 17 skip when fop - 1, wrapped to DATA_W bits, is zero or is non-zero, respectively. Classes 18 and 19 do the same for fop + 1.
- R9: Class 20 skips when fop is zero.
- R10: A skip sets next_pc to pc + 4. A request that neither jumps nor skips sets next_pc to pc + 2. This includes class 0 and classes 21 to 31. taken and skip_next are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Request present this cycle |
| op_class | input | 5 | Operation class code (R4 to R10) |
| pc | input | PC_W | Byte address of the current instruction |
| br_ofs | input | OFS_W | Signed word displacement |
| flags | input | 4 | Status flags {N, OV, Z, C} |
| wreg | input | DATA_W | Working register value |
| fop | input | DATA_W | Data operand |
| bit_sel | input | BS_W | Bit index used by the bit-test skips |
| res_valid | output | 1 | Result present |
| next_pc | output | PC_W | Resolved next program counter |
| taken | output | 1 | A relative jump or call was taken |
| skip_next | output | 1 | The next instruction word is skipped |
| push_en | output | 1 | Push push_addr onto the return stack |
| push_addr | output | PC_W | Return address for the relative call |

## Verification
The bench builds the block with PC_W = 16, OFS_W = 8 and DATA_W = 4. The narrow data path makes it possible to sweep every operand pair for the three compare skips and every operand and bit index for the bit-test, increment, decrement and zero-test skips. The 8-bit displacement can be swept completely for the unconditional jump, which covers both sign extremes. The jump classes are each run against all sixteen flag patterns. The 16-bit PC lets the bench place requests next to the top of the address space and check that targets, skip addresses and return addresses wrap.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

  localparam int OPC_W = 5;
  localparam int FLG_W = 4;

  // flag positions inside the flags vector
  localparam int FLG_C  = 0;
  localparam int FLG_Z  = 1;
  localparam int FLG_OV = 2;
  localparam int FLG_N  = 3;

  typedef enum logic [OPC_W-1:0] {
    OPC_IDLE      = 5'd0,
    OPC_BR_ALWAYS = 5'd1,
    OPC_BR_CARRY  = 5'd2,
    OPC_BR_NCARRY = 5'd3,
    OPC_BR_NEG    = 5'd4,
    OPC_BR_NNEG   = 5'd5,
    OPC_BR_OVF    = 5'd6,
    OPC_BR_NOVF   = 5'd7,
    OPC_BR_ZERO   = 5'd8,
    OPC_BR_NZERO  = 5'd9,
    OPC_CALL_REL  = 5'd10,
    OPC_SK_BITCLR = 5'd11,
    OPC_SK_BITSET = 5'd12,
    OPC_SK_EQ     = 5'd13,
    OPC_SK_GT     = 5'd14,
    OPC_SK_LT     = 5'd15,
    OPC_SK_DECZ   = 5'd16,
    OPC_SK_DECNZ  = 5'd17,
    OPC_SK_INCZ   = 5'd18,
    OPC_SK_INCNZ  = 5'd19,
    OPC_SK_TSTZ   = 5'd20
  } opc_e;

  // selection of the next PC source
  typedef enum logic [1:0] {
    NPC_SEQ  = 2'd0,
    NPC_SKIP = 2'd1,
    NPC_JUMP = 2'd2
  } npc_sel_e;

endpackage

// File: rtl/bsd_flag_cond.sv
module bsd_flag_cond
  import bsd_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  input  logic [FLG_W-1:0] flags,
  output logic             is_jump,
  output logic             cond_met,
  output logic             is_call
);

  logic f_c, f_z, f_ov, f_n;

  assign f_c  = flags[FLG_C];
  assign f_z  = flags[FLG_Z];
  assign f_ov = flags[FLG_OV];
  assign f_n  = flags[FLG_N];

  always_comb begin
    is_jump  = 1'b1;
    cond_met = 1'b0;
    is_call  = 1'b0;
    case (opc)
      OPC_BR_ALWAYS: cond_met = 1'b1;
      OPC_BR_CARRY:  cond_met = f_c;
      OPC_BR_NCARRY: cond_met = ~f_c;
      OPC_BR_NEG:    cond_met = f_n;
      OPC_BR_NNEG:   cond_met = ~f_n;
      OPC_BR_OVF:    cond_met = f_ov;
      OPC_BR_NOVF:   cond_met = ~f_ov;
      OPC_BR_ZERO:   cond_met = f_z;
      OPC_BR_NZERO:  cond_met = ~f_z;
      OPC_CALL_REL: begin
        cond_met = 1'b1;
        is_call  = 1'b1;
      end
      default:       is_jump = 1'b0;
    endcase
  end

endmodule

// File: rtl/bsd_skip_eval.sv
module bsd_skip_eval
  import bsd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BS_W   = 3
) (
  input  logic [OPC_W-1:0]  opc,
  input  logic [DATA_W-1:0] wreg,
  input  logic [DATA_W-1:0] fop,
  input  logic [BS_W-1:0]   bit_sel,
  output logic              is_skip,
  output logic              skip_hit
);

  logic [DATA_W-1:0] inc_res;
  logic [DATA_W-1:0] dec_res;
  logic              inc_zero;
  logic              dec_zero;
  logic              fop_zero;
  logic              sel_bit;
  logic              eq_w;
  logic              gt_w;
  logic              lt_w;

  assign inc_res  = fop + DATA_W'(1);
  assign dec_res  = fop - DATA_W'(1);
  assign inc_zero = (inc_res == '0);
  assign dec_zero = (dec_res == '0);
  assign fop_zero = (fop == '0);
  assign eq_w     = (fop == wreg);
  assign gt_w     = (fop > wreg);
  assign lt_w     = (fop < wreg);

  // bit picker; an index past the operand width reads as 0
  always_comb begin
    sel_bit = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (BS_W'(i) == bit_sel) sel_bit = fop[i];
    end
  end

  always_comb begin
    is_skip  = 1'b1;
    skip_hit = 1'b0;
    case (opc)
      OPC_SK_BITCLR: skip_hit = ~sel_bit;
      OPC_SK_BITSET: skip_hit = sel_bit;
      OPC_SK_EQ:     skip_hit = eq_w;
      OPC_SK_GT:     skip_hit = gt_w;
      OPC_SK_LT:     skip_hit = lt_w;
      OPC_SK_DECZ:   skip_hit = dec_zero;
      OPC_SK_DECNZ:  skip_hit = ~dec_zero;
      OPC_SK_INCZ:   skip_hit = inc_zero;
      OPC_SK_INCNZ:  skip_hit = ~inc_zero;
      OPC_SK_TSTZ:   skip_hit = fop_zero;
      default:       is_skip  = 1'b0;
    endcase
  end

endmodule

// File: rtl/bsd_pc_calc.sv
module bsd_pc_calc
  import bsd_pkg::*;
#(
  parameter int PC_W  = 21,
  parameter int OFS_W = 11
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFS_W-1:0] br_ofs,
  input  npc_sel_e         sel,
  output logic [PC_W-1:0]  next_pc,
  output logic [PC_W-1:0]  ret_addr
);

  localparam int SH_W = OFS_W + 1;

  logic [PC_W-1:0] disp;
  logic [PC_W-1:0] pc_seq;
  logic [PC_W-1:0] pc_skip;
  logic [PC_W-1:0] pc_jump;

  // word displacement scaled to bytes, sign-extended or truncated to the PC width
  generate
    if (PC_W > SH_W) begin : g_sext
      assign disp = {{(PC_W-SH_W){br_ofs[OFS_W-1]}}, br_ofs, 1'b0};
    end else begin : g_trunc
      logic [SH_W-1:0] disp_full;
      assign disp_full = {br_ofs, 1'b0};
      assign disp      = disp_full[PC_W-1:0];
    end
  endgenerate

  assign pc_seq   = pc + PC_W'(2);
  assign pc_skip  = pc + PC_W'(4);
  assign pc_jump  = pc_seq + disp;
  assign ret_addr = pc_seq;

  always_comb begin
    case (sel)
      NPC_SKIP: next_pc = pc_skip;
      NPC_JUMP: next_pc = pc_jump;
      default:  next_pc = pc_seq;
    endcase
  end

endmodule

// File: rtl/bsd_branch_unit.sv
module bsd_branch_unit
  import bsd_pkg::*;
#(
  parameter  int PC_W   = 21,
  parameter  int OFS_W  = 11,
  parameter  int DATA_W = 8,
  localparam int BS_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [4:0]        op_class,
  input  logic [PC_W-1:0]   pc,
  input  logic [OFS_W-1:0]  br_ofs,
  input  logic [3:0]        flags,
  input  logic [DATA_W-1:0] wreg,
  input  logic [DATA_W-1:0] fop,
  input  logic [BS_W-1:0]   bit_sel,
  output logic              res_valid,
  output logic [PC_W-1:0]   next_pc,
  output logic              taken,
  output logic              skip_next,
  output logic              push_en,
  output logic [PC_W-1:0]   push_addr
);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_int_n = rst_sync_q[1];

  // decision logic
  logic            is_jump, cond_met, is_call;
  logic            is_skip, skip_hit;
  logic            jump_d, skip_d;
  npc_sel_e        sel_d;
  logic [PC_W-1:0] npc_d;
  logic [PC_W-1:0] ret_d;

  bsd_flag_cond u_cond (
    .opc      (op_class),
    .flags    (flags),
    .is_jump  (is_jump),
    .cond_met (cond_met),
    .is_call  (is_call)
  );

  bsd_skip_eval #(
    .DATA_W (DATA_W),
    .BS_W   (BS_W)
  ) u_skip (
    .opc      (op_class),
    .wreg     (wreg),
    .fop      (fop),
    .bit_sel  (bit_sel),
    .is_skip  (is_skip),
    .skip_hit (skip_hit)
  );

  assign jump_d = is_jump & cond_met;
  assign skip_d = is_skip & skip_hit;

  always_comb begin
    if (jump_d)      sel_d = NPC_JUMP;
    else if (skip_d) sel_d = NPC_SKIP;
    else             sel_d = NPC_SEQ;
  end

  bsd_pc_calc #(
    .PC_W  (PC_W),
    .OFS_W (OFS_W)
  ) u_pc (
    .pc       (pc),
    .br_ofs   (br_ofs),
    .sel      (sel_d),
    .next_pc  (npc_d),
    .ret_addr (ret_d)
  );

  // next-state process
  logic            valid_q, valid_nxt;
  logic            taken_q, taken_nxt;
  logic            skip_q, skip_nxt;
  logic            push_q, push_nxt;
  logic [PC_W-1:0] npc_q, npc_nxt;
  logic [PC_W-1:0] ret_q, ret_nxt;
  logic            data_en;

  assign data_en = op_valid;

  always_comb begin
    valid_nxt = op_valid;
    taken_nxt = op_valid & jump_d;
    skip_nxt  = op_valid & skip_d;
    push_nxt  = op_valid & is_call;
    npc_nxt   = npc_q;
    ret_nxt   = ret_q;
    if (data_en) begin
      npc_nxt = npc_d;
      if (is_call) ret_nxt = ret_d;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q <= 1'b0;
      taken_q <= 1'b0;
      skip_q  <= 1'b0;
      push_q  <= 1'b0;
      npc_q   <= '0;
      ret_q   <= '0;
    end else begin
      valid_q <= valid_nxt;
      taken_q <= taken_nxt;
      skip_q  <= skip_nxt;
      push_q  <= push_nxt;
      npc_q   <= npc_nxt;
      ret_q   <= ret_nxt;
    end
  end

  assign res_valid = valid_q;
  assign taken     = taken_q;
  assign skip_next = skip_q;
  assign push_en   = push_q;
  assign next_pc   = npc_q;
  assign push_addr = ret_q;

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    op_valid |=> res_valid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !op_valid |=> (!res_valid && !taken && !skip_next && !push_en));

  // R10
  jump_skip_excl_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(taken && skip_next));

  // R5
  call_push_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    push_en |-> (taken && push_addr == PC_W'($past(pc) + PC_W'(2))));

  // R10
  skip_advance_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    skip_next |-> (next_pc == PC_W'($past(pc) + PC_W'(4))));

  // R10
  seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (res_valid && !taken && !skip_next) |-> (next_pc == PC_W'($past(pc) + PC_W'(2))));

  // R2
  result_flags_gated_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (taken || skip_next || push_en) |-> res_valid);

endmodule

// File: tb/bsd_branch_unit_bench.sv
module bsd_branch_unit_bench;

  localparam int PW = 16;
  localparam int OW = 8;
  localparam int DW = 4;
  localparam int BW = 2;
  localparam int PMASK = (1 << PW) - 1;
  localparam int DMASK = (1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          op_valid;
  logic [4:0]    op_class;
  logic [PW-1:0] pc;
  logic [OW-1:0] br_ofs;
  logic [3:0]    flags;
  logic [DW-1:0] wreg;
  logic [DW-1:0] fop;
  logic [BW-1:0] bit_sel;
  logic          res_valid;
  logic [PW-1:0] next_pc;
  logic          taken;
  logic          skip_next;
  logic          push_en;
  logic [PW-1:0] push_addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  bsd_branch_unit #(
    .PC_W   (PW),
    .OFS_W  (OW),
    .DATA_W (DW)
  ) u_bsd_branch_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_class  (op_class),
    .pc        (pc),
    .br_ofs    (br_ofs),
    .flags     (flags),
    .wreg      (wreg),
    .fop       (fop),
    .bit_sel   (bit_sel),
    .res_valid (res_valid),
    .next_pc   (next_pc),
    .taken     (taken),
    .skip_next (skip_next),
    .push_en   (push_en),
    .push_addr (push_addr)
  );

  function automatic string req_of(input int op);
    if (op >= 1 && op <= 9)        return "R4 (target R3)";
    else if (op == 10)             return "R5 (target R3)";
    else if (op == 11 || op == 12) return "R6 (advance R10)";
    else if (op >= 13 && op <= 15) return "R7 (advance R10)";
    else if (op >= 16 && op <= 19) return "R8 (advance R10)";
    else if (op == 20)             return "R9 (advance R10)";
    return "R10";
  endfunction

  // reference model built from the requirement text
  task automatic model(input int op, input int p, input int o, input int fl,
                       input int w, input int f, input int bs,
                       output int npc, output int tk, output int sk, output int ps);
    int c, z, v, n, d;
    c = fl & 1; z = (fl >> 1) & 1; v = (fl >> 2) & 1; n = (fl >> 3) & 1;
    tk = 0; sk = 0; ps = 0;
    case (op)
      1:  tk = 1;
      2:  tk = c;
      3:  tk = 1 - c;
      4:  tk = n;
      5:  tk = 1 - n;
      6:  tk = v;
      7:  tk = 1 - v;
      8:  tk = z;
      9:  tk = 1 - z;
      10: begin tk = 1; ps = 1; end
      11: sk = (((f >> bs) & 1) == 0) ? 1 : 0;
      12: sk = (((f >> bs) & 1) == 1) ? 1 : 0;
      13: sk = (f == w) ? 1 : 0;
      14: sk = (f > w) ? 1 : 0;
      15: sk = (f < w) ? 1 : 0;
      16: sk = (((f - 1) & DMASK) == 0) ? 1 : 0;
      17: sk = (((f - 1) & DMASK) != 0) ? 1 : 0;
      18: sk = (((f + 1) & DMASK) == 0) ? 1 : 0;
      19: sk = (((f + 1) & DMASK) != 0) ? 1 : 0;
      20: sk = (f == 0) ? 1 : 0;
      default: ;
    endcase
    d = (o >= (1 << (OW - 1))) ? o - (1 << OW) : o;
    if (tk != 0)      npc = (p + 2 + 2 * d) & PMASK;
    else if (sk != 0) npc = (p + 4) & PMASK;
    else              npc = (p + 2) & PMASK;
  endtask

  task automatic run_vec(input int op, input int p, input int o, input int fl,
                         input int w, input int f, input int bs);
    int e_npc, e_tk, e_sk, e_ps, e_ret;
    bit ok;
    @(negedge clk);
    op_valid = 1'b1;
    op_class = 5'(op);
    pc       = PW'(p);
    br_ofs   = OW'(o);
    flags    = 4'(fl);
    wreg     = DW'(w);
    fop      = DW'(f);
    bit_sel  = BW'(bs);
    model(op, p, o, fl, w, f, bs, e_npc, e_tk, e_sk, e_ps);
    e_ret = (p + 2) & PMASK;
    @(negedge clk);
    n_checks++;
    ok = (res_valid == 1'b1) && (int'(next_pc) == e_npc) && (int'(taken) == e_tk)
         && (int'(skip_next) == e_sk) && (int'(push_en) == e_ps)
         && ((e_ps == 0) || (int'(push_addr) == e_ret));
    if (!ok) begin
      n_fail++;
      $display("FAIL %s op=%0d pc=%h ofs=%h fl=%h w=%0d f=%0d bs=%0d: actual v=%0b npc=%h tk=%0b sk=%0b ps=%0b ret=%h expected v=1 npc=%h tk=%0d sk=%0d ps=%0d ret=%h",
               req_of(op), op, p, o, fl, w, f, bs, res_valid, next_pc, taken, skip_next,
               push_en, push_addr, e_npc, e_tk, e_sk, e_ps, e_ret);
    end
  endtask

  // R2: idle cycle leaves no result
  task automatic run_idle();
    @(negedge clk);
    op_valid = 1'b0;
    op_class = 5'd1;
    @(negedge clk);
    n_checks++;
    if (res_valid || taken || skip_next || push_en) begin
      n_fail++;
      $display("FAIL R2 idle: actual v=%0b tk=%0b sk=%0b ps=%0b expected all 0",
               res_valid, taken, skip_next, push_en);
    end
  endtask

  task automatic check_reset_state(input string where);
    n_checks++;
    if (res_valid || taken || skip_next || push_en || next_pc != '0 || push_addr != '0) begin
      n_fail++;
      $display("FAIL R1 %s: actual v=%0b tk=%0b sk=%0b ps=%0b npc=%h ret=%h expected zeros",
               where, res_valid, taken, skip_next, push_en, next_pc, push_addr);
    end
  endtask

  initial begin
    int ofs_list[12];
    int pc_list[4];
    ofs_list = '{0, 1, 2, 5, 63, 127, 128, 129, 200, 254, 255, 64};
    pc_list  = '{16'h0000, 16'h1234, 16'hFFFE, 16'h8000};
    rst_n    = 1'b0;
    op_valid = 1'b0;
    op_class = '0;
    pc       = '0;
    br_ofs   = '0;
    flags    = '0;
    wreg     = '0;
    fop      = '0;
    bit_sel  = '0;
    repeat (3) @(negedge clk);
    // R1 during reset, with a request pending on the inputs
    op_valid = 1'b1;
    op_class = 5'd10;
    @(negedge clk);
    check_reset_state("in reset");
    op_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset_state("after release");

    run_idle();

    // R4, R5, R3: jump classes against every flag pattern and a spread of offsets
    for (int op = 1; op <= 10; op++)
      for (int fl = 0; fl < 16; fl++)
        for (int k = 0; k < 12; k++)
          run_vec(op, pc_list[(fl + k) % 4], ofs_list[k], fl, 0, 0, 0);

    // R3: full displacement sweep near the top and bottom of the address space
    for (int o = 0; o < 256; o++) run_vec(1, 16'hFF00, o, 0, 0, 0, 0);
    for (int o = 0; o < 256; o++) run_vec(1, 16'h0010, o, 0, 0, 0, 0);

    run_idle();

    // R6: bit-test skips over every operand and bit index
    for (int op = 11; op <= 12; op++)
      for (int f = 0; f < 16; f++)
        for (int bs = 0; bs < 4; bs++)
          run_vec(op, 16'h0400, 8'h7F, 4'hF, 0, f, bs);

    // R7: unsigned compares over every operand pair
    for (int op = 13; op <= 15; op++)
      for (int w = 0; w < 16; w++)
        for (int f = 0; f < 16; f++)
          run_vec(op, (w * 16 + f) * 2, 8'h80, 4'hF, w, f, 0);

    // R8, R9: increment, decrement and zero-test skips, including wrap at the top
    for (int op = 16; op <= 20; op++)
      for (int f = 0; f < 16; f++) begin
        run_vec(op, 16'hFFFC, 8'h05, 4'hF, f ^ 5, f, 0);
        run_vec(op, 16'hFFFE, 8'hF0, 4'h0, 0, f, 3);
      end

    // R10: unused and idle class codes advance sequentially
    for (int op = 0; op < 32; op++)
      if (op == 0 || op >= 21) begin
        run_vec(op, 16'hFFFE, 8'h40, 4'hF, 0, 0, 0);
        run_vec(op, 16'h0100, 8'h80, 4'h0, 3, 3, 1);
      end

    run_idle();
    run_idle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual run still active, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule